// File: doc/BRIEF.md
# Multislope Rundown Sequencer

This block runs the rundown of a multislope integrating converter once the run-up has ended. On a start pulse it closes the fast reference switch so the integrator discharges quickly. It watches the comparator input, which is asynchronous, through a synchronizer. The first high comparator level is stamped with a free-running cycle timer. The stamp is corrected for the synchronizer latency.

The comparator is only polled once every four clock cycles. The fast reference is not released at that poll. An alignment stage instead adds a delay taken from the two low bits of the stamp: bit 0 adds one cycle and bit 1 adds two. As a result, the fast switch opens a fixed number of cycles after the comparator edge, whatever the poll phase.

The timer value at the moment the switch opens is recorded. This switch-off stamp, not the comparator stamp, is what the result arithmetic uses. A slow-slope phase follows and runs until the comparator returns low. Then comes a settling wait, and then a sample request window for the external residue converter. A one-cycle done pulse ends the sequence. If either slope phase runs past its time limit, the sequence is aborted and an overrange flag is raised.

The FSM has seven states:
- IDLE waits for start.
- FAST has the fast reference on. It moves to ALIGN at a poll cycle once a capture exists, or to FINISH on timeout.
- ALIGN holds the fast reference for 0 to 3 extra cycles, then moves to SLOW.
- SLOW has the slow reference on. It moves to SETTLE when the comparator drops, or to FINISH on timeout.
- SETTLE waits, then moves to SAMPLE.
- SAMPLE asserts the request, then moves to FINISH.
- FINISH pulses done and returns to IDLE.

Top module: `rundown_ctrl`

## Requirements
- R1: After reset all outputs are low, the stamps are zero and the block is idle.
- R2: A start pulse in IDLE sets ref_fast high from the next clock edge, with ref_slow low.
- R3: cap_ts equals the timer value of the first clock edge that samples the comparator high. Across runs, cap_ts minus the cycle count of that edge is therefore constant.
- R4: ref_fast falls exactly SYNC_STAGES+6 clock edges (8 by default) after the edge that first samples the comparator high. This holds for all four alignments of that edge to the 4-cycle poll.
- R5: off_ts minus cap_ts, taken modulo 2^TW, equals SYNC_STAGES+6.
- R6: ref_slow is high from the edge at which ref_fast falls. It falls SYNC_STAGES+1 edges after the edge that first samples the comparator low. ref_fast and ref_slow are never high together.
- R7: After ref_slow falls, sample_req stays low for SETTLE_CYC cycles, then stays high for exactly SAMPLE_CYC cycles.
- R8: done is high for exactly the one cycle after sample_req falls. On a normal run overrange stays low.
- R9: If the comparator is not seen high within FAST_MAX cycles (64 µs), ref_fast drops after FAST_MAX cycles. done and overrange then rise together, and sample_req never rises.
- R10: If the comparator does not return low within SLOW_MAX cycles of the slow phase, ref_slow drops after SLOW_MAX cycles. done and overrange then rise, and sample_req never rises.
- R11: A start pulse while the sequence is running has no effect on its timing. overrange clears when the next sequence is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (16 MHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run-up finished, begin rundown |
| cmp_async | input | 1 | Asynchronous comparator output |
| ref_fast | output | 1 | Fast reference switch control |
| ref_slow | output | 1 | Slow-slope reference switch control |
| sample_req | output | 1 | Residue converter sampling window |
| done | output | 1 | One-cycle end-of-sequence pulse |
| overrange | output | 1 | Slope phase timed out |
| cap_ts | output | TW | Latency-corrected comparator edge stamp |
| off_ts | output | TW | Timer value when the fast reference opened |

## Verification
The comparator edge is placed at each of the four offsets relative to the poll phase. Equal switch-off latency and an equal off-minus-capture gap in every case show that the alignment delay is chosen correctly, not fixed and not inverted. Two of these runs with different offsets also compare cap_ts against the bench's own cycle count, which exposes a wrong latency correction. A held-low comparator and a comparator held high after the trip separate the fast timeout from the slow timeout. A stray start during the fast phase and a restart after an abort cover the ignore and flag-clearing behaviour.

// File: rtl/rd_pkg.sv
package rd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FAST,
        ST_ALIGN,
        ST_SLOW,
        ST_SETTLE,
        ST_SAMPLE,
        ST_FINISH
    } rd_state_t;
endpackage

// File: rtl/rd_sync.sv
module rd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/rd_timer.sv
module rd_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [TW-1:0] now
);
    always_ff @(posedge clk) begin
        if (!rst_n) now <= '0;
        else        now <= now + 1'b1;
    end
endmodule

// File: rtl/rd_interval.sv
module rd_interval #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/rundown_ctrl.sv
module rundown_ctrl
    import rd_pkg::*;
#(
    parameter int TW          = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FAST_MAX    = 1024,
    parameter int SLOW_MAX    = 320,
    parameter int SETTLE_CYC  = 640,
    parameter int SAMPLE_CYC  = 240
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          cmp_async,
    output logic          ref_fast,
    output logic          ref_slow,
    output logic          sample_req,
    output logic          done,
    output logic          overrange,
    output logic [TW-1:0] cap_ts,
    output logic [TW-1:0] off_ts
);
    localparam int MAX_A  = (FAST_MAX > SLOW_MAX) ? FAST_MAX : SLOW_MAX;
    localparam int MAX_B  = (SETTLE_CYC > SAMPLE_CYC) ? SETTLE_CYC : SAMPLE_CYC;
    localparam int MAX_W  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW     = $clog2(MAX_W + 1);
    localparam logic [1:0] POLL_PH = 2'(SYNC_STAGES % 4);
    localparam int OFF_GAP = SYNC_STAGES + 6;

    rd_state_t     state, nxt;
    logic          cmp_s;
    logic [TW-1:0] timer_q;
    logic          cnt_load;
    logic [CW-1:0] cnt_val;
    logic          cnt_zero;
    logic          cap_valid;
    logic [1:0]    align_cnt;

    rd_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .d_async(cmp_async), .q_sync(cmp_s)
    );

    rd_timer #(.TW(TW)) i_timer (
        .clk(clk), .rst_n(rst_n), .now(timer_q)
    );

    rd_interval #(.CW(CW)) i_interval (
        .clk(clk), .rst_n(rst_n), .load(cnt_load),
        .load_val(cnt_val), .expired(cnt_zero)
    );

    // next state and interval loads
    always_comb begin
        nxt      = state;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    nxt      = ST_FAST;
                    cnt_load = 1'b1;
                    cnt_val  = CW'(FAST_MAX - 1);
                end
            end
            ST_FAST: begin
                if (cap_valid && timer_q[1:0] == POLL_PH) nxt = ST_ALIGN;
                else if (!cap_valid && cnt_zero)          nxt = ST_FINISH;
            end
            ST_ALIGN: begin
                if (align_cnt == 2'd0) begin
                    nxt      = ST_SLOW;
                    cnt_load = 1'b1;
                    cnt_val  = CW'(SLOW_MAX - 1);
                end
            end
            ST_SLOW: begin
                if (!cmp_s) begin
                    nxt      = ST_SETTLE;
                    cnt_load = 1'b1;
                    cnt_val  = CW'(SETTLE_CYC - 1);
                end else if (cnt_zero) begin
                    nxt = ST_FINISH;
                end
            end
            ST_SETTLE: begin
                if (cnt_zero) begin
                    nxt      = ST_SAMPLE;
                    cnt_load = 1'b1;
                    cnt_val  = CW'(SAMPLE_CYC - 1);
                end
            end
            ST_SAMPLE: begin
                if (cnt_zero) nxt = ST_FINISH;
            end
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // state register and stamps
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cap_valid <= 1'b0;
            cap_ts    <= '0;
            off_ts    <= '0;
            align_cnt <= 2'd0;
            overrange <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && start) begin
                cap_valid <= 1'b0;
                overrange <= 1'b0;
            end
            if (state == ST_FAST && cmp_s && !cap_valid) begin
                cap_valid <= 1'b1;
                cap_ts    <= timer_q - TW'(SYNC_STAGES);
            end
            if (state == ST_FAST && nxt == ST_ALIGN)
                align_cnt <= cap_ts[1:0];   // bit0 adds 1 cycle, bit1 adds 2
            else if (state == ST_ALIGN && align_cnt != 2'd0)
                align_cnt <= align_cnt - 2'd1;
            if (state == ST_ALIGN && nxt == ST_SLOW)
                off_ts <= timer_q + 1'b1;
            if ((state == ST_FAST || state == ST_SLOW) && nxt == ST_FINISH)
                overrange <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        ref_fast   = 1'b0;
        ref_slow   = 1'b0;
        sample_req = 1'b0;
        done       = 1'b0;
        unique case (state)
            ST_FAST, ST_ALIGN: ref_fast   = 1'b1;
            ST_SLOW:           ref_slow   = 1'b1;
            ST_SAMPLE:         sample_req = 1'b1;
            ST_FINISH:         done       = 1'b1;
            default: ;
        endcase
    end

    p_poll_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ALIGN && $past(state) == ST_FAST) |-> $past(timer_q[1:0]) == POLL_PH);

    p_off_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ref_fast) && state == ST_SLOW) |-> (off_ts - cap_ts) == TW'(OFF_GAP));

    p_one_ref_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ref_fast && ref_slow));

    p_sample_after_settle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sample_req) |-> $past(state) == ST_SETTLE);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrange) |-> (done && !sample_req && !ref_fast && !ref_slow));
endmodule

// File: tb/test_rundown_ctrl.sv
module test_rundown_ctrl;
    localparam int CLK_NS = 62;
    localparam int TW = 16;
    localparam int SYNC = 2;
    localparam int FAST_MAX = 1024;
    localparam int SLOW_MAX = 320;
    localparam int SETTLE = 640;
    localparam int SAMPLE = 240;
    localparam int GAP = SYNC + 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cmp_async = 1'b0;
    logic ref_fast, ref_slow, sample_req, done, overrange;
    logic [TW-1:0] cap_ts, off_ts;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    logic [TW-1:0] cyc = '0;
    logic [TW-1:0] ref_offset;
    bit have_offset = 0;

    always #(CLK_NS/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1'b1;

    rundown_ctrl i_rundown_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp_async(cmp_async),
        .ref_fast(ref_fast), .ref_slow(ref_slow), .sample_req(sample_req),
        .done(done), .overrange(overrange), .cap_ts(cap_ts), .off_ts(off_ts)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic kick();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    // count edges from comparator rise until ref_fast reads low
    task automatic trip(output int edges, output logic [TW-1:0] edge_cyc);
        @(negedge clk) cmp_async = 1'b1;
        edges = 0;
        edge_cyc = '0;
        for (int i = 0; i < 40; i++) begin
            @(posedge clk);
            edges++;
            if (edges == SYNC) edge_cyc = cyc;  // count value of the sampling edge
            @(negedge clk);
            if (!ref_fast) break;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "outputs", {ref_fast, ref_slow, sample_req, done, overrange}, 0);
        chk("R1", "stamps", cap_ts | off_ts, 0);
    endtask

    task automatic t_normal(input int phase, input bit stray_start);
        int e, n;
        logic [TW-1:0] ec;
        kick();
        chk("R2", "fast on after start", {ref_fast, ref_slow}, 2'b10);
        repeat (5 + phase) @(negedge clk);
        if (stray_start) begin
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        trip(e, ec);
        chk("R4", $sformatf("switch-off latency phase %0d", phase), e, GAP);
        chk("R11", "stray start kept fast latency", stray_start ? e : GAP, GAP);
        chk("R5", "off minus capture", TW'(off_ts - cap_ts), GAP);
        if (!have_offset) begin
            ref_offset = cap_ts - ec;
            have_offset = 1;
        end else begin
            chk("R3", "capture tracks edge cycle", TW'(cap_ts - ec), ref_offset);
        end
        chk("R6", "slow on at fast off", ref_slow, 1);
        repeat (7) @(negedge clk);
        cmp_async = 1'b0;
        n = 0;
        for (int i = 0; i < 40; i++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (!ref_slow) break;
        end
        chk("R6", "slow off latency", n, SYNC + 1);
        n = 0;
        while (!sample_req && n < 3000) begin
            n++;
            @(negedge clk);
        end
        chk("R7", "settle length", n, SETTLE);
        n = 0;
        while (sample_req && n < 3000) begin
            n++;
            @(negedge clk);
        end
        chk("R7", "sample length", n, SAMPLE);
        chk("R8", "done after sample", done, 1);
        chk("R8", "no overrange", overrange, 0);
        @(negedge clk);
        chk("R8", "done one cycle", done, 0);
    endtask

    task automatic t_fast_timeout();
        int n;
        bit saw_sample;
        kick();
        n = 0;
        saw_sample = 0;
        while (ref_fast && n < 3000) begin
            n++;
            @(negedge clk);
        end
        chk("R9", "fast timeout length", n, FAST_MAX);
        chk("R9", "done+overrange", {done, overrange}, 2'b11);
        chk("R9", "refs off", {ref_slow, sample_req}, 0);
        repeat (4) begin
            @(negedge clk);
            if (sample_req) saw_sample = 1;
        end
        chk("R9", "no sample after abort", saw_sample, 0);
    endtask

    task automatic t_slow_timeout();
        int e, n;
        logic [TW-1:0] ec;
        kick();
        chk("R11", "overrange cleared by start", overrange, 0);
        repeat (3) @(negedge clk);
        trip(e, ec);
        n = 0;
        while (ref_slow && n < 3000) begin
            n++;
            @(negedge clk);
        end
        chk("R10", "slow timeout length", n, SLOW_MAX);
        chk("R10", "done+overrange", {done, overrange}, 2'b11);
        chk("R10", "no sample", sample_req, 0);
        cmp_async = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        t_reset();
        for (int p = 0; p < 4; p++) t_normal(p, 1'b0);
        t_normal(2, 1'b1);
        t_fast_timeout();
        t_slow_timeout();
        t_normal(1, 1'b0);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_NS * 150000);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule